// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences power-down for a small microcontroller core. The core decodes a sleep instruction and raises a one-cycle request. The controller then clears the watchdog count while leaving the watchdog running. It also updates the power-down and time-out status flags and drops the clock-run output that enables the oscillator driver. Because the core clock is gated, the output port registers keep the drive values they held before sleep.

While asleep the controller watches three kinds of wake source. The external reset pin forces a full core reset. Watchdog expiry wakes the core only if the watchdog is enabled. An interrupt line wakes the core only if its own enable bit is set and the line belongs to an asynchronous source. Lines served by peripherals that need the internal clocks never wake the core. Wake does not depend on the global interrupt enable. That enable only decides whether the core continues in line or branches to the interrupt vector after it executes the prefetched next instruction.

In the crystal-type clock modes the controller holds the core for an oscillator start-up delay before resuming. In RC mode it resumes at once. Resumption is a one-cycle pulse, with a vector-select output beside it.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After the synchronous reset, clk_run is 1, pd_flag is 1, to_flag is 1, and resume, vector_sel, wdt_clr and core_reset are 0.
- R2: A sleep_req while running (no resume pulse and no sleep in progress) has these effects in the next cycle: wdt_clr is 1 for exactly one cycle, pd_flag is 0, to_flag is 1, and clk_run is 0 unless R8 applies.
- R3: While asleep, irq_pend[i] & irq_en[i] wakes the core for any line i whose bit is set in ASYNC_MASK (default lines 0..2), whatever the value of gie. A pending line with its enable clear does not wake the core. Neither does line 3, which is outside the default mask. In both cases clk_run stays 0.
- R4: While asleep, wdt_timeout wakes the core only if wdt_en is 1, and that wake clears to_flag to 0. A timeout with wdt_en = 0, or a timeout while running, leaves to_flag and the state unchanged.
- R5: If osc_mode is 0, 1 or 2 (crystal-type), clk_run stays 0 and resume stays 0 for OST_CYCLES cycles after the wake edge, and resume rises on the next cycle. If osc_mode is 3 (RC), resume is 1 in the cycle right after the wake edge.
- R6: resume is high for exactly one cycle, with clk_run = 1. In that cycle vector_sel equals the gie value sampled at the wake edge: 1 means branch to the interrupt vector, 0 means continue in line. The flags keep their values through resume.
- R7: ext_rst at any time gives a core_reset pulse of one cycle in the next cycle, with clk_run = 1 and resume = 0, and leaves pd_flag and to_flag unchanged.
- R8: A sleep_req in a cycle where a wake source is already valid still updates the flags and pulses wdt_clr. It then yields resume = 1 in the next cycle, and clk_run never drops.
- R9: A sleep_req while asleep is ignored: wdt_clr stays 0 and the core stays asleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_req | input | 1 | One-cycle decoded sleep instruction |
| ext_rst | input | 1 | External reset pin, synchronised, active high |
| wdt_en | input | 1 | Watchdog enable |
| wdt_timeout | input | 1 | Watchdog expiry strobe |
| irq_pend | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| gie | input | 1 | Global interrupt enable |
| osc_mode | input | 2 | 0 LP, 1 XT, 2 HS, 3 RC |
| clk_run | output | 1 | Oscillator and core clock enable |
| wdt_clr | output | 1 | Watchdog count clear pulse |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Time-out status flag |
| resume | output | 1 | One-cycle resume pulse |
| vector_sel | output | 1 | With resume: 1 branch to the interrupt vector, 0 in line |
| core_reset | output | 1 | One-cycle full core reset pulse |

## Verification
The bench runs the start-up count to its exact end. A counter off by one would raise resume one cycle early or late, or would let clk_run rise while the oscillator is still settling. It wakes with gie both set and clear. A design that gated wake on gie would stay asleep, and one that sampled gie late would report the wrong vector. Disabled lines, the clock-dependent line, and a timeout with the watchdog disabled are each applied alone while asleep. A design that ignored a qualifier would raise clk_run there. The bench also issues a sleep request with a source already pending, and an external reset during sleep. A design that skipped the flag update on immediate wake, or that altered the flags on reset, would show the wrong pd_flag or to_flag.

// File: rtl/slpw_pkg.sv
package slpw_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_OST    = 2'd2,
    ST_RESUME = 2'd3
  } slpw_state_e;

  typedef enum logic [1:0] {
    OSC_LP = 2'd0,
    OSC_XT = 2'd1,
    OSC_HS = 2'd2,
    OSC_RC = 2'd3
  } slpw_osc_e;

  // crystal-type modes need the start-up hold, RC does not
  function automatic logic needs_ost(input logic [1:0] mode);
    return mode != OSC_RC;
  endfunction
endpackage

// File: rtl/slpw_wake_sel.sv
module slpw_wake_sel #(
  parameter int N_IRQ = 4,
  parameter logic [N_IRQ-1:0] ASYNC_MASK = '1
) (
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wdt_en,
  input  logic             wdt_timeout,
  output logic             wake_irq,
  output logic             wake_wdt,
  output logic             wake_any
);
  logic [N_IRQ-1:0] qual;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    if (ASYNC_MASK[i]) begin : g_async
      assign qual[i] = irq_pend[i] & irq_en[i];
    end else begin : g_clocked
      assign qual[i] = 1'b0;
    end
  end

  assign wake_irq = |qual;
  assign wake_wdt = wdt_en & wdt_timeout;
  assign wake_any = wake_irq | wake_wdt;
endmodule

// File: rtl/slpw_ost_timer.sv
module slpw_ost_timer #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(OST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || start) cnt <= '0;
    else if (run && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/slpw_status_flags.sv
module slpw_status_flags (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic wdt_wake,
  output logic pd_flag,
  output logic to_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_flag <= 1'b1;
      to_flag <= 1'b1;
    end else begin
      if (enter) pd_flag <= 1'b0;
      if (wdt_wake) to_flag <= 1'b0;
      else if (enter) to_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import slpw_pkg::*;
#(
  parameter int N_IRQ = 4,
  parameter logic [N_IRQ-1:0] ASYNC_MASK = 4'b0111,
  parameter int OST_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             ext_rst,
  input  logic             wdt_en,
  input  logic             wdt_timeout,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  input  logic [1:0]       osc_mode,
  output logic             clk_run,
  output logic             wdt_clr,
  output logic             pd_flag,
  output logic             to_flag,
  output logic             resume,
  output logic             vector_sel,
  output logic             core_reset
);
  slpw_state_e state_q, state_d;
  logic wake_irq, wake_wdt, wake_any;
  logic enter, wake_now, ost_start, ost_done;
  logic vec_lat;

  slpw_wake_sel #(.N_IRQ(N_IRQ), .ASYNC_MASK(ASYNC_MASK)) u_wake (
    .irq_pend(irq_pend), .irq_en(irq_en), .wdt_en(wdt_en),
    .wdt_timeout(wdt_timeout), .wake_irq(wake_irq),
    .wake_wdt(wake_wdt), .wake_any(wake_any)
  );

  slpw_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk(clk), .rst(rst), .start(ost_start),
    .run(state_q == ST_OST), .done(ost_done)
  );

  slpw_status_flags u_flags (
    .clk(clk), .rst(rst), .enter(enter),
    .wdt_wake(wake_now & wake_wdt),
    .pd_flag(pd_flag), .to_flag(to_flag)
  );

  always_comb begin
    state_d  = state_q;
    enter    = 1'b0;
    wake_now = 1'b0;
    if (ext_rst) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN: if (sleep_req) begin
          enter = 1'b1;
          if (wake_any) begin
            wake_now = 1'b1;
            state_d  = ST_RESUME;
          end else begin
            state_d = ST_SLEEP;
          end
        end
        ST_SLEEP: if (wake_any) begin
          wake_now = 1'b1;
          state_d  = needs_ost(osc_mode) ? ST_OST : ST_RESUME;
        end
        ST_OST:    if (ost_done) state_d = ST_RESUME;
        ST_RESUME: state_d = ST_RUN;
        default:   state_d = ST_RUN;
      endcase
    end
  end

  assign ost_start = (state_q != ST_OST) && (state_d == ST_OST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      clk_run    <= 1'b1;
      wdt_clr    <= 1'b0;
      resume     <= 1'b0;
      vector_sel <= 1'b0;
      core_reset <= 1'b0;
      vec_lat    <= 1'b0;
    end else begin
      state_q    <= state_d;
      clk_run    <= (state_d == ST_RUN) || (state_d == ST_RESUME);
      wdt_clr    <= enter;
      resume     <= (state_d == ST_RESUME);
      core_reset <= ext_rst;
      if (wake_now) vec_lat <= gie;
      vector_sel <= (state_d == ST_RESUME) && (wake_now ? gie : vec_lat);
    end
  end
endmodule

// File: rtl/slpw_chk.sv
module slpw_chk (
  input logic clk,
  input logic rst,
  input logic sleep_req,
  input logic ext_rst,
  input logic clk_run,
  input logic wdt_clr,
  input logic pd_flag,
  input logic resume,
  input logic core_reset,
  input logic [1:0] state
);
  // R2
  entry_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !ext_rst && state == 2'd0) |=> (wdt_clr && !pd_flag));
  // R2
  clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_clr |=> !wdt_clr);
  // R6
  resume_single_chk: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume);
  // R6
  resume_clock_chk: assert property (@(posedge clk) disable iff (rst)
    resume |-> clk_run);
  // R7
  ext_reset_chk: assert property (@(posedge clk) disable iff (rst)
    ext_rst |=> (core_reset && clk_run && !resume));
  // R9
  no_reentry_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd1 && !ext_rst) |=> !wdt_clr);
endmodule

bind sleep_wake_ctrl slpw_chk u_chk (
  .clk(clk), .rst(rst), .sleep_req(sleep_req), .ext_rst(ext_rst),
  .clk_run(clk_run), .wdt_clr(wdt_clr), .pd_flag(pd_flag),
  .resume(resume), .core_reset(core_reset), .state(state_q)
);

// File: tb/sim_sleep_wake_ctrl.sv
module sim_sleep_wake_ctrl;
  localparam int OST = 1024;
  logic clk = 1'b0, rst = 1'b1;
  logic sleep_req = 0, ext_rst = 0, wdt_en = 0, wdt_timeout = 0, gie = 0;
  logic [3:0] irq_pend = '0, irq_en = '0;
  logic [1:0] osc_mode = 2'd1;
  logic clk_run, wdt_clr, pd_flag, to_flag, resume, vector_sel, core_reset;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl u0 (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .ext_rst(ext_rst),
    .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .irq_pend(irq_pend),
    .irq_en(irq_en), .gie(gie), .osc_mode(osc_mode), .clk_run(clk_run),
    .wdt_clr(wdt_clr), .pd_flag(pd_flag), .to_flag(to_flag),
    .resume(resume), .vector_sel(vector_sel), .core_reset(core_reset)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    rst = 1; sleep_req = 0; ext_rst = 0; wdt_en = 0; wdt_timeout = 0;
    gie = 0; irq_pend = '0; irq_en = '0; osc_mode = 2'd1;
    step(); step(); rst = 0;
  endtask

  task automatic enter_sleep();
    sleep_req = 1; step(); sleep_req = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 clk_run", clk_run, 1); chk("R1 pd", pd_flag, 1);
    chk("R1 to", to_flag, 1); chk("R1 resume", resume, 0);
    chk("R1 vector_sel", vector_sel, 0); chk("R1 wdt_clr", wdt_clr, 0);
    chk("R1 core_reset", core_reset, 0);
  endtask

  task automatic t_irq_xtal(input logic g);
    do_reset(); osc_mode = 2'd1; gie = g;
    enter_sleep();
    chk("R2 clk_run low", clk_run, 0); chk("R2 wdt_clr", wdt_clr, 1);
    chk("R2 pd", pd_flag, 0); chk("R2 to", to_flag, 1);
    step(); chk("R2 wdt_clr single", wdt_clr, 0);
    irq_pend = 4'b0001; irq_en = 4'b0001; step(); irq_pend = '0;
    chk("R3 woke, clock held", clk_run, 0);
    for (int i = 0; i < OST - 1; i++) step();
    chk("R5 clk_run low at end", clk_run, 0); chk("R5 resume not yet", resume, 0);
    step();
    chk("R5 resume", resume, 1); chk("R6 clk_run", clk_run, 1);
    chk("R6 vector_sel", vector_sel, g);
    chk("R6 pd held", pd_flag, 0); chk("R6 to held", to_flag, 1);
    step(); chk("R6 resume single", resume, 0);
  endtask

  task automatic t_ignored_irq();
    do_reset(); osc_mode = 2'd3;
    enter_sleep(); step();
    irq_pend = 4'b0010; irq_en = 4'b0000; step(); step();
    chk("R3 disabled line", clk_run, 0);
    irq_pend = 4'b1000; irq_en = 4'b1000; step(); step();
    chk("R3 clocked line", clk_run, 0); chk("R3 no resume", resume, 0);
    irq_pend = 4'b0100; irq_en = 4'b0100; step(); irq_pend = '0;
    chk("R5 RC resume", resume, 1);
  endtask

  task automatic t_wdt();
    do_reset(); osc_mode = 2'd3;
    wdt_timeout = 1; step(); wdt_timeout = 0;
    chk("R4 run timeout to", to_flag, 1);
    enter_sleep(); step();
    wdt_en = 0; wdt_timeout = 1; step(); wdt_timeout = 0; step();
    chk("R4 disabled no wake", clk_run, 0); chk("R4 disabled to", to_flag, 1);
    wdt_en = 1; wdt_timeout = 1; step(); wdt_timeout = 0;
    chk("R4 wake resume", resume, 1); chk("R4 to cleared", to_flag, 0);
    chk("R6 vector_sel inline", vector_sel, 0);
  endtask

  task automatic t_ext_reset();
    do_reset(); enter_sleep(); step();
    ext_rst = 1; step(); ext_rst = 0;
    chk("R7 core_reset", core_reset, 1); chk("R7 clk_run", clk_run, 1);
    chk("R7 resume", resume, 0); chk("R7 pd kept", pd_flag, 0);
    chk("R7 to kept", to_flag, 1);
    step(); chk("R7 single", core_reset, 0);
  endtask

  task automatic t_immediate();
    do_reset(); gie = 1; irq_pend = 4'b0001; irq_en = 4'b0001;
    sleep_req = 1; step(); sleep_req = 0; irq_pend = '0;
    chk("R8 wdt_clr", wdt_clr, 1); chk("R8 pd", pd_flag, 0);
    chk("R8 resume", resume, 1); chk("R8 clk_run", clk_run, 1);
    chk("R8 vector_sel", vector_sel, 1);
    do_reset(); wdt_en = 1; wdt_timeout = 1;
    sleep_req = 1; step(); sleep_req = 0; wdt_timeout = 0;
    chk("R8 wdt immediate to", to_flag, 0); chk("R8 wdt resume", resume, 1);
  endtask

  task automatic t_req_asleep();
    do_reset(); enter_sleep(); step();
    sleep_req = 1; step(); sleep_req = 0;
    chk("R9 no wdt_clr", wdt_clr, 0); chk("R9 still asleep", clk_run, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_irq_xtal(1'b1); t_irq_xtal(1'b0); t_ignored_irq();
        t_wdt(); t_ext_reset(); t_immediate(); t_req_asleep();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run hung actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule